// File: doc/BRIEF.md
# Erase Timing and Status Toggler

This block keeps track of erase progress inside a parallel NOR flash model and forms the status byte that a read returns while the part is busy. A command decoder elsewhere turns bus writes into single-cycle pulses. These pulses add a sector to an erase batch, start a chip erase, suspend or resume a sector erase, abort an open batch, or mark a status read. A clock-enable input supplies one pulse per microsecond. The block keeps the erase state and the countdowns, and it tells the read path whether a read at a given sector must return the status byte instead of array data. Clearing the array and decoding the bus commands are done outside this block.

A sector erase does not start at once. Each accepted request marks its sector in a bitmap and re-arms a short acceptance window. When the window closes without a new request, a countdown starts whose length is the number of pending sectors times a per-sector erase time. A chip erase runs a single fixed countdown. A sector erase can be suspended: the time still remaining is saved, and on resume the countdown continues from that value. Status reads flip the toggle bits according to the current mode. This lets software poll for completion and tell a sector that is being erased from one that is suspended.

Top module: `erase_status_timer`

## Requirements
- R1: After a synchronous reset the status byte is 0x00, the erase bitmap is all zero, and busy, suspended and the read-returns-status flag are low.
- R2: A sector-erase request in idle or in the open window sets bit i of the bitmap for sector index i and clears DQ7 (status bit 7). It raises busy and restarts the window at WINDOW_TICKS ticks. A request for a sector whose bit is already set re-arms the window but does not add to the pending count.
- R3: When the window runs out, DQ3 (status bit 3) is set. An erase countdown of pending × 2^SECTOR_EXP × TICKS_PER_MS ticks then starts, and it ends on its last tick.
- R4: An abort pulse while the window is open clears the bitmap and returns the block to idle. An abort pulse at any other time has no effect.
- R5: When a sector erase countdown ends, the bitmap is cleared, DQ3 is cleared, DQ7 is inverted, and busy falls.
- R6: A chip erase started in idle clears DQ7 and stays busy for 2^CHIP_EXP × TICKS_PER_MS ticks, then inverts DQ7. While it runs, sector, abort and suspend pulses have no effect.
- R7: A status read while busy toggles DQ6 (bit 6) and DQ2 (bit 2). In idle with a program in progress, it toggles only DQ6. In idle with no program, it changes nothing.
- R8: A suspend pulse in the window saves the full erase duration. In a running erase it saves the ticks left, which is at least 1. In both cases DQ3 is cleared, the countdown stops, suspended goes high and busy goes low.
- R9: While suspended, a read at a sector marked in the bitmap asserts the read-returns-status flag, and a status read there toggles only DQ2. A read at an unmarked sector deasserts the flag and changes nothing.
- R10: Resume restarts the countdown from the saved value and clears the saved value. It clears DQ7 and sets DQ3.
- R11: While suspended, sector-erase and chip-erase requests are rejected and leave the bitmap and the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-microsecond clock enable |
| sec_add_i | input | 1 | Sector-erase request pulse |
| sec_idx_i | input | IDX_W | Sector index of the request |
| chip_erase_i | input | 1 | Chip-erase start pulse |
| suspend_i | input | 1 | Erase-suspend pulse |
| resume_i | input | 1 | Erase-resume pulse |
| abort_i | input | 1 | Any other write, aborts an open window |
| stat_rd_i | input | 1 | Read strobe that consumes a toggle |
| rd_sector_i | input | IDX_W | Sector index of the current read |
| prog_active_i | input | 1 | A program operation is in progress |
| status_o | output | 8 | Status byte (DQ7, DQ6, DQ3, DQ2) |
| busy_o | output | 1 | Window, sector erase or chip erase in progress |
| suspended_o | output | 1 | Sector erase suspended |
| rd_status_o | output | 1 | Read at rd_sector_i returns the status byte |
| erase_map_o | output | NUM_SECTORS | Bitmap of sectors being erased |

## Verification
A behavioural model is compared with the design on every cycle while the tick arrives every cycle and, in another phase, every second cycle. This exposes off-by-one errors in the window and countdown lengths that would stay hidden at a single rate. The batch patterns are: a single sector, several sectors with a re-armed window and a duplicate, and an abort inside the window. Together they separate pending-count scaling from window handling. Suspend is tried both inside the window and in mid-countdown, so the saved-full-duration case is told apart from the saved-remainder case. Reads at marked and unmarked sectors while suspended, and reads in program, chip-erase and idle modes, separate the per-mode toggle rules.

// File: rtl/erase_tgl_pkg.sv
package erase_tgl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WINDOW,
        ST_ERASE,
        ST_CHIP,
        ST_SUSP
    } er_state_e;

    // one bit per status manipulation requested in a cycle
    typedef struct packed {
        logic tog_dq6;
        logic tog_dq2;
        logic clr_dq7;
        logic inv_dq7;
        logic set_dq3;
        logic clr_dq3;
    } stat_op_t;

    localparam int DQ7 = 7;
    localparam int DQ6 = 6;
    localparam int DQ3 = 3;
    localparam int DQ2 = 2;

    function automatic longint unsigned ms_to_ticks(int exp2, int ticks_per_ms);
        return (64'd1 << exp2) * longint'(ticks_per_ms);
    endfunction

    function automatic longint unsigned max3(longint unsigned a, longint unsigned b,
                                             longint unsigned c);
        longint unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/est_countdown.sv
module est_countdown #(
    parameter int T_W = 24
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick_i,
    input  logic           clr_i,
    input  logic           load_i,
    input  logic [T_W-1:0] load_val_i,
    output logic [T_W-1:0] cnt_o,
    output logic           expire_o
);
    logic [T_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)                 cnt_q <= '0;
        else if (load_i)                  cnt_q <= load_val_i;
        else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_o    = cnt_q;
    assign expire_o = tick_i && (cnt_q == T_W'(1));

    // R3
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !load_i) |=> cnt_q == '0);
endmodule

// File: rtl/est_sector_track.sv
module est_sector_track #(
    parameter int NUM_SECTORS = 32,
    parameter int IDX_W       = 5,
    parameter int CNT_W       = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   add_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  logic                   clr_i,
    output logic [NUM_SECTORS-1:0] map_o,
    output logic [CNT_W-1:0]       pend_o
);
    logic [NUM_SECTORS-1:0] map_q;
    logic [CNT_W-1:0]       pend_q;
    logic                   fresh;

    assign fresh = add_i && !map_q[idx_i];

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            map_q  <= '0;
            pend_q <= '0;
        end else if (fresh) begin
            map_q[idx_i] <= 1'b1;
            pend_q       <= pend_q + 1'b1;
        end
    end

    assign map_o  = map_q;
    assign pend_o = pend_q;

    // R2
    pend_match_chk: assert property (@(posedge clk) disable iff (rst)
        32'(pend_q) == $countones(map_q));
endmodule

// File: rtl/est_status_reg.sv
module est_status_reg
    import erase_tgl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  stat_op_t   op_i,
    output logic [7:0] stat_o
);
    logic [7:0] stat_q;
    logic [7:0] stat_d;

    always_comb begin
        stat_d = stat_q;
        if (op_i.tog_dq6) stat_d[DQ6] = ~stat_d[DQ6];
        if (op_i.tog_dq2) stat_d[DQ2] = ~stat_d[DQ2];
        if (op_i.clr_dq7) stat_d[DQ7] = 1'b0;
        if (op_i.inv_dq7) stat_d[DQ7] = ~stat_d[DQ7];
        if (op_i.set_dq3) stat_d[DQ3] = 1'b1;
        if (op_i.clr_dq3) stat_d[DQ3] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= 8'h00;
        else     stat_q <= stat_d;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/erase_status_timer.sv
module erase_status_timer
    import erase_tgl_pkg::*;
#(
    parameter int NUM_SECTORS  = 32,
    parameter int TICKS_PER_MS = 1000,
    parameter int WINDOW_TICKS = 50,
    parameter int SECTOR_EXP   = 9,
    parameter int CHIP_EXP     = 12,
    localparam int IDX_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick_i,
    input  logic                   sec_add_i,
    input  logic [IDX_W-1:0]       sec_idx_i,
    input  logic                   chip_erase_i,
    input  logic                   suspend_i,
    input  logic                   resume_i,
    input  logic                   abort_i,
    input  logic                   stat_rd_i,
    input  logic [IDX_W-1:0]       rd_sector_i,
    input  logic                   prog_active_i,
    output logic [7:0]             status_o,
    output logic                   busy_o,
    output logic                   suspended_o,
    output logic                   rd_status_o,
    output logic [NUM_SECTORS-1:0] erase_map_o
);
    localparam int CNT_W = $clog2(NUM_SECTORS + 1);
    localparam longint unsigned SECT_UNIT = ms_to_ticks(SECTOR_EXP, TICKS_PER_MS);
    localparam longint unsigned CHIP_T    = ms_to_ticks(CHIP_EXP, TICKS_PER_MS);
    localparam longint unsigned MAX_T     =
        max3(SECT_UNIT * longint'(NUM_SECTORS), CHIP_T, longint'(WINDOW_TICKS));
    localparam int T_W = $clog2(MAX_T + 1);

    er_state_e        state_q, state_d;
    logic [T_W-1:0]   saved_q, cnt, load_val, save_val, full_dur;
    logic             load, cclr, expire, add, tclr, save_en, saved_clr;
    logic             idx_ok, rd_ok, rd_hit;
    logic [CNT_W-1:0] pend;
    stat_op_t         op;

    // index range checks only exist when the sector count is not a power of two
    generate
        if (NUM_SECTORS == (1 << IDX_W)) begin : g_full_range
            assign idx_ok = 1'b1;
            assign rd_ok  = 1'b1;
        end else begin : g_part_range
            assign idx_ok = (32'(sec_idx_i) < NUM_SECTORS);
            assign rd_ok  = (32'(rd_sector_i) < NUM_SECTORS);
        end
    endgenerate

    assign rd_hit   = rd_ok && erase_map_o[rd_sector_i];
    assign full_dur = T_W'(pend) * T_W'(SECT_UNIT);

    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        load_val  = '0;
        cclr      = 1'b0;
        add       = 1'b0;
        tclr      = 1'b0;
        save_en   = 1'b0;
        save_val  = '0;
        saved_clr = 1'b0;
        op        = '0;

        if (stat_rd_i) begin
            unique case (state_q)
                ST_WINDOW, ST_ERASE, ST_CHIP: begin
                    op.tog_dq6 = 1'b1;
                    op.tog_dq2 = 1'b1;
                end
                ST_IDLE: op.tog_dq6 = prog_active_i;
                ST_SUSP: op.tog_dq2 = rd_hit;
                default: ;
            endcase
        end

        unique case (state_q)
            ST_IDLE: begin
                if (sec_add_i && idx_ok) begin
                    add        = 1'b1;
                    op.clr_dq7 = 1'b1;
                    load       = 1'b1;
                    load_val   = T_W'(WINDOW_TICKS);
                    state_d    = ST_WINDOW;
                end else if (chip_erase_i) begin
                    op.clr_dq7 = 1'b1;
                    load       = 1'b1;
                    load_val   = T_W'(CHIP_T);
                    state_d    = ST_CHIP;
                end
            end
            ST_WINDOW: begin
                if (suspend_i) begin
                    save_en    = 1'b1;
                    save_val   = full_dur;
                    op.clr_dq3 = 1'b1;
                    cclr       = 1'b1;
                    state_d    = ST_SUSP;
                end else if (sec_add_i && idx_ok) begin
                    add        = 1'b1;
                    op.clr_dq7 = 1'b1;
                    load       = 1'b1;
                    load_val   = T_W'(WINDOW_TICKS);
                end else if (abort_i) begin
                    tclr    = 1'b1;
                    cclr    = 1'b1;
                    state_d = ST_IDLE;
                end else if (expire) begin
                    op.set_dq3 = 1'b1;
                    load       = 1'b1;
                    load_val   = full_dur;
                    state_d    = ST_ERASE;
                end
            end
            ST_ERASE: begin
                if (suspend_i) begin
                    save_en    = 1'b1;
                    save_val   = cnt;
                    op.clr_dq3 = 1'b1;
                    cclr       = 1'b1;
                    state_d    = ST_SUSP;
                end else if (expire) begin
                    tclr       = 1'b1;
                    op.clr_dq3 = 1'b1;
                    op.inv_dq7 = 1'b1;
                    state_d    = ST_IDLE;
                end
            end
            ST_CHIP: begin
                if (expire) begin
                    op.inv_dq7 = 1'b1;
                    state_d    = ST_IDLE;
                end
            end
            ST_SUSP: begin
                if (resume_i) begin
                    load       = 1'b1;
                    load_val   = saved_q;
                    saved_clr  = 1'b1;
                    op.clr_dq7 = 1'b1;
                    op.set_dq3 = 1'b1;
                    state_d    = ST_ERASE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            saved_q <= '0;
        end else begin
            state_q <= state_d;
            if (save_en)        saved_q <= save_val;
            else if (saved_clr) saved_q <= '0;
        end
    end

    est_countdown #(.T_W(T_W)) u_cnt (
        .clk(clk), .rst(rst), .tick_i(tick_i), .clr_i(cclr), .load_i(load),
        .load_val_i(load_val), .cnt_o(cnt), .expire_o(expire)
    );

    est_sector_track #(.NUM_SECTORS(NUM_SECTORS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst(rst), .add_i(add), .idx_i(sec_idx_i), .clr_i(tclr),
        .map_o(erase_map_o), .pend_o(pend)
    );

    est_status_reg u_stat (
        .clk(clk), .rst(rst), .op_i(op), .stat_o(status_o)
    );

    assign busy_o      = (state_q == ST_WINDOW) || (state_q == ST_ERASE) || (state_q == ST_CHIP);
    assign suspended_o = (state_q == ST_SUSP);
    assign rd_status_o = busy_o || ((state_q == ST_IDLE) && prog_active_i)
                         || ((state_q == ST_SUSP) && rd_hit);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && sec_add_i && idx_ok)
        |=> erase_map_o[$past(sec_idx_i)] && !status_o[DQ7] && busy_o);
    // R5
    finish_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ERASE && expire && !suspend_i)
        |=> erase_map_o == '0 && !status_o[DQ3] && status_o[DQ7] != $past(status_o[DQ7]));
    // R6
    chip_map_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHIP) |-> erase_map_o == '0);
    // R7
    busy_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_ERASE || state_q == ST_CHIP) && stat_rd_i)
        |=> status_o[DQ6] != $past(status_o[DQ6]) && status_o[DQ2] != $past(status_o[DQ2]));
    // R8
    susp_saved_chk: assert property (@(posedge clk) disable iff (rst)
        suspended_o |-> (saved_q != '0) && !busy_o && !status_o[DQ3]);
    // R11
    susp_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUSP && (sec_add_i || chip_erase_i)) |=> $stable(erase_map_o));
endmodule

// File: tb/erase_status_timer_tb_top.sv
module erase_status_timer_tb_top;
    localparam int NS    = 8;
    localparam int TPM   = 2;
    localparam int WIN   = 6;
    localparam int SEXP  = 1;
    localparam int CEXP  = 3;
    localparam int UNIT  = (1 << SEXP) * TPM;
    localparam int CHIPT = (1 << CEXP) * TPM;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, tick, sec_add, chip, sus, res, abt, rd, prog;
    logic [2:0] sec_idx, rd_sec;
    logic [7:0] status;
    logic busy, susp_o, rd_status;
    logic [NS-1:0] map;

    erase_status_timer #(
        .NUM_SECTORS(NS), .TICKS_PER_MS(TPM), .WINDOW_TICKS(WIN),
        .SECTOR_EXP(SEXP), .CHIP_EXP(CEXP)
    ) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .sec_add_i(sec_add), .sec_idx_i(sec_idx),
        .chip_erase_i(chip), .suspend_i(sus), .resume_i(res), .abort_i(abt),
        .stat_rd_i(rd), .rd_sector_i(rd_sec), .prog_active_i(prog),
        .status_o(status), .busy_o(busy), .suspended_o(susp_o),
        .rd_status_o(rd_status), .erase_map_o(map)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int tick_div = 1;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural reference: 0 idle, 1 window, 2 erasing, 3 chip, 4 suspended
    int m_state, m_cnt, m_saved, m_pend;
    logic [NS-1:0] m_map;
    logic [7:0] m_st;

    task automatic cmp(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_cnt = 0; m_saved = 0; m_pend = 0; m_map = '0; m_st = 8'h00;
    endtask

    task automatic model_add();
        if (!m_map[sec_idx]) begin
            m_map[sec_idx] = 1'b1;
            m_pend++;
        end
    endtask

    function automatic bit model_rdstat();
        return (m_state >= 1 && m_state <= 3) || (m_state == 0 && prog)
               || (m_state == 4 && m_map[rd_sec]);
    endfunction

    task automatic model_step();
        logic [7:0] s;
        s = m_st;
        if (rd) begin
            if (m_state >= 1 && m_state <= 3) s = s ^ 8'h44;
            else if (m_state == 0 && prog) s = s ^ 8'h40;
            else if (m_state == 4 && m_map[rd_sec]) s = s ^ 8'h04;
        end
        case (m_state)
            0: if (sec_add) begin
                   model_add(); s[7] = 1'b0; m_cnt = WIN; m_state = 1;
               end else if (chip) begin
                   s[7] = 1'b0; m_cnt = CHIPT; m_state = 3;
               end
            1: if (sus) begin
                   m_saved = m_pend * UNIT; s[3] = 1'b0; m_cnt = 0; m_state = 4;
               end else if (sec_add) begin
                   model_add(); s[7] = 1'b0; m_cnt = WIN;
               end else if (abt) begin
                   m_map = '0; m_pend = 0; m_cnt = 0; m_state = 0;
               end else if (tick && m_cnt == 1) begin
                   s[3] = 1'b1; m_cnt = m_pend * UNIT; m_state = 2;
               end else if (tick) m_cnt--;
            2: if (sus) begin
                   m_saved = m_cnt; s[3] = 1'b0; m_cnt = 0; m_state = 4;
               end else if (tick && m_cnt == 1) begin
                   m_map = '0; m_pend = 0; s[3] = 1'b0; s[7] = ~s[7]; m_cnt = 0; m_state = 0;
               end else if (tick) m_cnt--;
            3: if (tick && m_cnt == 1) begin
                   s[7] = ~s[7]; m_cnt = 0; m_state = 0;
               end else if (tick) m_cnt--;
            4: if (res) begin
                   m_cnt = m_saved; m_saved = 0; s[7] = 1'b0; s[3] = 1'b1; m_state = 2;
               end
            default: ;
        endcase
        m_st = s;
    endtask

    // one clock: called just after a falling edge, returns just after the next one
    task automatic cycle();
        tick = ((cyc % tick_div) == 0);
        #1;
        cmp(cur_req, "rd_status", rd_status, model_rdstat());
        @(posedge clk);
        if (rst) model_reset();
        else     model_step();
        @(negedge clk);
        cmp(cur_req, "status", status, m_st);
        cmp(cur_req, "busy", busy, int'(m_state >= 1 && m_state <= 3));
        cmp(cur_req, "suspended", susp_o, int'(m_state == 4));
        cmp(cur_req, "map", map, m_map);
        sec_add = 0; chip = 0; sus = 0; res = 0; abt = 0; rd = 0;
        cyc++;
    endtask

    task automatic run(int n, bit reads);
        for (int i = 0; i < n; i++) begin
            rd = reads && (i % 2 == 0);
            cycle();
        end
    endtask

    task automatic add_sector(int idx);
        sec_idx = 3'(idx); sec_add = 1; cycle();
    endtask

    initial begin
        logic [7:0] snap;
        rst = 1; tick = 0; sec_add = 0; chip = 0; sus = 0; res = 0; abt = 0;
        rd = 0; prog = 0; sec_idx = 0; rd_sec = 0;
        model_reset();
        @(negedge clk);
        cycle(); cycle();
        rst = 0;
        cycle();
        // R1 reset state
        cmp("R1", "status after reset", status, 8'h00);
        cmp("R1", "map after reset", map, 0);
        cmp("R1", "busy after reset", busy, 0);

        // R2/R3/R5 single sector, timing counted by hand
        cur_req = "R2";
        add_sector(3);
        cmp("R2", "map sector3", map, 8'h08);
        cmp("R2", "dq7 cleared", status[7], 0);
        cmp("R2", "busy", busy, 1);
        cur_req = "R3";
        run(5, 1);
        cmp("R3", "dq3 before window end", status[3], 0);
        run(1, 1);
        cmp("R3", "dq3 at window end", status[3], 1);
        run(UNIT - 1, 1);
        cmp("R3", "busy before countdown end", busy, 1);
        cur_req = "R5";
        run(1, 1);
        cmp("R5", "busy at end", busy, 0);
        cmp("R5", "map cleared", map, 0);
        cmp("R5", "dq7 inverted", status[7], 1);
        cmp("R5", "dq3 cleared", status[3], 0);

        // R2/R3 batch with re-arm and duplicate, tick every second cycle
        cur_req = "R2";
        tick_div = 2;
        add_sector(1);
        run(4, 0);
        add_sector(5);
        run(2, 1);
        add_sector(1);
        cmp("R2", "duplicate keeps map", map, 8'h22);
        cur_req = "R3";
        run(2 * (WIN + 2 * UNIT) + 4, 1);
        cmp("R3", "batch finished", busy, 0);
        tick_div = 1;

        // R4 abort in window, ignored during erase
        cur_req = "R4";
        add_sector(2);
        run(2, 0);
        abt = 1; cycle();
        cmp("R4", "abort clears map", map, 0);
        cmp("R4", "abort idles", busy, 0);
        add_sector(6);
        run(WIN + 1, 0);
        abt = 1; cycle();
        cmp("R4", "abort ignored in erase", busy, 1);
        cmp("R4", "map kept", map, 8'h40);
        run(UNIT, 0);

        // R6/R7 chip erase
        cur_req = "R6";
        chip = 1; cycle();
        cmp("R6", "chip busy", busy, 1);
        cmp("R6", "chip dq7", status[7], 0);
        add_sector(4);
        cmp("R6", "sector ignored in chip", map, 0);
        sus = 1; cycle();
        cmp("R6", "suspend ignored in chip", susp_o, 0);
        cur_req = "R7";
        snap = status;
        rd = 1; cycle();
        cmp("R7", "chip read toggles dq6 dq2", status, snap ^ 8'h44);
        cur_req = "R6";
        run(CHIPT, 1);
        cmp("R6", "chip done", busy, 0);

        // R7 program and idle reads
        cur_req = "R7";
        prog = 1;
        snap = status;
        rd = 1; cycle();
        cmp("R7", "program read toggles dq6", status, snap ^ 8'h40);
        run(4, 1);
        prog = 0;
        snap = status;
        rd = 1; cycle();
        cmp("R7", "idle read no toggle", status, snap);

        // R8/R9/R10/R11 suspend inside the window
        cur_req = "R8";
        add_sector(0);
        add_sector(7);
        run(2, 0);
        sus = 1; cycle();
        cmp("R8", "suspended", susp_o, 1);
        cmp("R8", "busy low", busy, 0);
        cmp("R8", "dq3 low", status[3], 0);
        run(5, 0);
        cur_req = "R9";
        rd_sec = 7; #1;
        cmp("R9", "marked sector reads status", rd_status, 1);
        snap = status;
        rd = 1; cycle();
        cmp("R9", "marked read toggles dq2 only", status, snap ^ 8'h04);
        rd_sec = 3; #1;
        cmp("R9", "unmarked sector reads array", rd_status, 0);
        snap = status;
        rd = 1; cycle();
        cmp("R9", "unmarked read no toggle", status, snap);
        cur_req = "R11";
        add_sector(3);
        cmp("R11", "add rejected", map, 8'h81);
        chip = 1; cycle();
        cmp("R11", "chip rejected", susp_o, 1);
        cur_req = "R10";
        res = 1; cycle();
        cmp("R10", "resume busy", busy, 1);
        cmp("R10", "resume dq3", status[3], 1);
        cmp("R10", "resume dq7", status[7], 0);
        run(2 * UNIT - 1, 1);
        cmp("R10", "full duration running", busy, 1);
        run(1, 0);
        cmp("R10", "full duration done", busy, 0);

        // R8/R10 suspend mid-countdown keeps the remainder
        cur_req = "R8";
        add_sector(4);
        run(WIN + 1, 0);
        sus = 1; cycle();
        run(6, 1);
        cmp("R8", "countdown stopped", susp_o, 1);
        cur_req = "R10";
        res = 1; cycle();
        run(UNIT - 2, 0);
        cmp("R10", "remainder running", busy, 1);
        run(1, 0);
        cmp("R10", "remainder done", busy, 0);
        cmp("R10", "map cleared", map, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule